// File: doc/BRIEF.md
# I2C Write-Only Word Target

This block is a receive-only I2C target that lives in a system clock domain. It oversamples the SCL and SDA lines, finds START and STOP conditions, and recognises its own 7-bit address. It then accepts exactly two data bytes and places them into a 16-bit register: the first byte goes to the upper half and the second byte goes to the lower half.

The target acknowledges the address byte and both data bytes by pulling SDA low through an open-drain enable. Apart from those acknowledge slots it never drives the bus. Six address bits are fixed. The seventh, the LSB, is the inverse of a board strap input. This lets two targets share one bus.

A one-cycle strobe marks each half of the register as it is written. Downstream logic can therefore act on the upper byte alone or on the completed word. Read transfers, clock stretching, general call and bus-speed checks are not handled.

Top module: `i2c_word_target`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Bits clocked on the bus without a preceding START are not acknowledged and change nothing.
- R2: After a START, the first byte is 7 address bits, MSB first, then a R/W bit. The byte is acknowledged only if the address equals {001011, ~strap_i} and R/W is 0. With strap_i=0 the address is 0010111; with strap_i=1 it is 0010110.
- R3: If the address does not match, or R/W is 1, no acknowledge is given for that byte or for any later byte, and word_o does not change until the next START or STOP.
- R4: An acknowledge asserts sda_oe_o while SCL is low after the eighth bit. SDA then stays low for the whole high phase of the ninth clock, and sda_oe_o is released while SCL is low after that clock.
- R5: The first data byte after an accepted address is written to word_o[15:8] and acknowledged. hi_stb_o pulses for exactly one cycle in the cycle word_o[15:8] takes the new value. word_o[15:8] changes at no other time.
- R6: The second data byte is written to word_o[7:0] and acknowledged. lo_stb_o pulses for exactly one cycle in the cycle word_o[7:0] takes the new value. word_o[7:0] changes at no other time.
- R7: sda_oe_o is never asserted outside an acknowledge slot. Bytes after the second data byte are not acknowledged and leave word_o unchanged.
- R8: A repeated START at any point restarts address reception. The following header is judged afresh.
- R9: A STOP in the middle of a byte discards the partial byte. word_o and the strobes are unaffected, and the next transaction works normally.
- R10: While rst is high, and after it, word_o is zero, sda_oe_o is low and both strobes are low until a byte is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level as seen on the wired bus |
| strap_i | input | 1 | Address select strap; its inverse forms the address LSB |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| word_o | output | 16 | Received word: first data byte high, second data byte low |
| hi_stb_o | output | 1 | One-cycle pulse when word_o[15:8] is written |
| lo_stb_o | output | 1 | One-cycle pulse when word_o[7:0] is written |

## Verification
A protocol state that is out of step shows at the ports within one byte time. The acknowledge for the address or for a data byte appears where none is expected, or goes missing. A bit counter that is off by one shifts the captured byte, so word_o disagrees with the expected value at the STOP that ends the transfer. A stuck or stretched enable shows up as SDA held low outside the ninth clock. A strobe that is doubled or missing is caught by counting pulses per transaction.

// File: rtl/i2c_word_pkg.sv
package i2c_word_pkg;

  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_A,
    ST_HI,
    ST_ACK_H,
    ST_LO,
    ST_ACK_L,
    ST_SKIP
  } rx_state_t;

  // Header byte that this target accepts: address then write bit (0)
  function automatic logic [BYTE_W-1:0] write_header(input logic [5:0] prefix,
                                                     input logic       strap);
    return {prefix, ~strap, 1'b0};
  endfunction

endpackage

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_lvl;
  logic scl_q;
  logic sda_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      logic scl_r, sda_r;
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_r <= 1'b1;
          sda_r <= 1'b1;
        end else begin
          scl_r <= scl_i;
          sda_r <= sda_i;
        end
      end
      assign scl_lvl = scl_r;
      assign sda_lvl = sda_r;
    end else begin : g_many
      logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
        end
      end
      assign scl_lvl = scl_pipe[SYNC_STAGES-1];
      assign sda_lvl = sda_pipe[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_lvl;
      sda_q <= sda_lvl;
    end
  end

  assign scl_rise  = scl_lvl & ~scl_q;
  assign scl_fall  = ~scl_lvl & scl_q;
  assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/i2c_bit_shifter.sv
module i2c_bit_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            sample,
  input  logic            bit_i,
  output logic [BITS-1:0] data_o,
  output logic            full_o
);

  localparam int CNT_W = $clog2(BITS + 1);

  logic [CNT_W-1:0] cnt;

  assign full_o = (cnt == CNT_W'(BITS));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt    <= '0;
      data_o <= '0;
    end else if (sample && !full_o) begin
      cnt    <= cnt + 1'b1;
      data_o <= {data_o[BITS-2:0], bit_i};
    end
  end

endmodule

// File: rtl/i2c_word_ctrl.sv
module i2c_word_ctrl
  import i2c_word_pkg::*;
#(
  parameter logic [5:0] ADDR_PREFIX = 6'b001011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_i,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              byte_full,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              shift_clr,
  output logic              take_hi,
  output logic              take_lo,
  output logic              sda_oe
);

  rx_state_t state;
  logic      in_ack;
  logic      byte_end;

  assign in_ack    = (state == ST_ACK_A) || (state == ST_ACK_H) || (state == ST_ACK_L);
  assign byte_end  = scl_fall && byte_full;
  assign shift_clr = start_det || stop_det || (scl_fall && in_ack);
  assign take_hi   = !start_det && !stop_det && (state == ST_HI) && byte_end;
  assign take_lo   = !start_det && !stop_det && (state == ST_LO) && byte_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: if (byte_end) begin
          if (rx_byte == write_header(ADDR_PREFIX, strap_i)) begin
            state  <= ST_ACK_A;
            sda_oe <= 1'b1;
          end else begin
            state <= ST_SKIP;
          end
        end
        ST_ACK_A: if (scl_fall) begin
          state  <= ST_HI;
          sda_oe <= 1'b0;
        end
        ST_HI: if (byte_end) begin
          state  <= ST_ACK_H;
          sda_oe <= 1'b1;
        end
        ST_ACK_H: if (scl_fall) begin
          state  <= ST_LO;
          sda_oe <= 1'b0;
        end
        ST_LO: if (byte_end) begin
          state  <= ST_ACK_L;
          sda_oe <= 1'b1;
        end
        ST_ACK_L: if (scl_fall) begin
          state  <= ST_SKIP;
          sda_oe <= 1'b0;
        end
        default: sda_oe <= 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/i2c_word_target.sv
module i2c_word_target
  import i2c_word_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] ADDR_PREFIX = 6'b001011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              strap_i,
  output logic              sda_oe_o,
  output logic [WORD_W-1:0] word_o,
  output logic              hi_stb_o,
  output logic              lo_stb_o
);

  logic              sda_lvl;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic              shift_clr;
  logic              byte_full;
  logic [BYTE_W-1:0] rx_byte;
  logic              take_hi;
  logic              take_lo;

  i2c_bus_sampler #(
    .SYNC_STAGES(SYNC_STAGES)
  ) sampler_i (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_bit_shifter #(
    .BITS(BYTE_W)
  ) shifter_i (
    .clk   (clk),
    .rst   (rst),
    .clr   (shift_clr),
    .sample(scl_rise),
    .bit_i (sda_lvl),
    .data_o(rx_byte),
    .full_o(byte_full)
  );

  i2c_word_ctrl #(
    .ADDR_PREFIX(ADDR_PREFIX)
  ) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .strap_i  (strap_i),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .byte_full(byte_full),
    .rx_byte  (rx_byte),
    .shift_clr(shift_clr),
    .take_hi  (take_hi),
    .take_lo  (take_lo),
    .sda_oe   (sda_oe_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o   <= '0;
      hi_stb_o <= 1'b0;
      lo_stb_o <= 1'b0;
    end else begin
      hi_stb_o <= take_hi;
      lo_stb_o <= take_lo;
      if (take_hi) word_o[WORD_W-1:BYTE_W] <= rx_byte;
      if (take_lo) word_o[BYTE_W-1:0]      <= rx_byte;
    end
  end

endmodule

// File: rtl/i2c_word_target_chk.sv
module i2c_word_target_chk
  import i2c_word_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              scl_i,
  input logic              sda_oe_o,
  input logic [WORD_W-1:0] word_o,
  input logic              hi_stb_o,
  input logic              lo_stb_o
);

  a_r10_reset_state: assert property (@(posedge clk)
    rst |=> (word_o == '0 && !sda_oe_o && !hi_stb_o && !lo_stb_o));

  a_r5_hi_single_pulse: assert property (@(posedge clk) disable iff (rst)
    hi_stb_o |=> !hi_stb_o);

  a_r6_lo_single_pulse: assert property (@(posedge clk) disable iff (rst)
    lo_stb_o |=> !lo_stb_o);

  a_r5_hi_only_on_strobe: assert property (@(posedge clk) disable iff (rst)
    !hi_stb_o |-> $stable(word_o[WORD_W-1:BYTE_W]));

  a_r6_lo_only_on_strobe: assert property (@(posedge clk) disable iff (rst)
    !lo_stb_o |-> $stable(word_o[BYTE_W-1:0]));

  a_r5_hi_acked: assert property (@(posedge clk) disable iff (rst)
    hi_stb_o |-> sda_oe_o);

  a_r6_lo_acked: assert property (@(posedge clk) disable iff (rst)
    lo_stb_o |-> sda_oe_o);

  a_r4_drive_while_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe_o) |-> !scl_i);

  a_r4_release_while_scl_low: assert property (@(posedge clk) disable iff (rst)
    $fell(sda_oe_o) |-> !scl_i);

  a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(hi_stb_o && lo_stb_o));

endmodule

bind i2c_word_target i2c_word_target_chk chk_i (
  .clk     (clk),
  .rst     (rst),
  .scl_i   (scl_i),
  .sda_oe_o(sda_oe_o),
  .word_o  (word_o),
  .hi_stb_o(hi_stb_o),
  .lo_stb_o(lo_stb_o)
);

// File: tb/i2c_word_target_tb_top.sv
`timescale 1ns/1ps
module i2c_word_target_tb_top;

  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        strap = 1'b0;
  logic        ack_win = 1'b0;
  logic        sda_bus;
  logic        sda_oe;
  logic [15:0] word;
  logic        hi_stb;
  logic        lo_stb;

  int checks = 0;
  int fails = 0;
  int hi_seen = 0;
  int lo_seen = 0;
  int stray = 0;
  bit done = 1'b0;
  logic [15:0] word_exp = 16'h0000;

  assign sda_bus = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_word_target dut_i (
    .clk     (clk),
    .rst     (rst),
    .scl_i   (scl_m),
    .sda_i   (sda_bus),
    .strap_i (strap),
    .sda_oe_o(sda_oe),
    .word_o  (word),
    .hi_stb_o(hi_stb),
    .lo_stb_o(lo_stb)
  );

  always @(negedge clk) begin
    if (hi_stb) hi_seen++;
    if (lo_stb) lo_seen++;
    if (sda_oe && !ack_win) stray++;
  end

  function automatic logic [6:0] exp_addr(input logic s);
    return {6'b001011, ~s};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start;
    sda_m = 1'b1; idle(Q);
    scl_m = 1'b1; idle(Q);
    sda_m = 1'b0; idle(Q);
    scl_m = 1'b0; idle(Q);
  endtask

  task automatic m_stop;
    sda_m = 1'b0; idle(Q);
    scl_m = 1'b1; idle(Q);
    sda_m = 1'b1; idle(Q);
  endtask

  task automatic m_bit(input logic b, input bit last);
    sda_m = b;    idle(Q);
    scl_m = 1'b1; idle(2 * Q);
    if (last) ack_win = 1'b1;
    scl_m = 1'b0; idle(Q);
  endtask

  // Sends a byte; acked is 1 only if SDA stayed low for the whole ninth high phase
  task automatic m_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) m_bit(b[i], i == 0);
    sda_m = 1'b1; idle(Q);
    scl_m = 1'b1;
    acked = 1'b1;
    repeat (2 * Q) begin
      @(negedge clk);
      if (sda_bus) acked = 1'b0;
    end
    scl_m = 1'b0; idle(Q);
    check("R4 released after ninth clock", {31'd0, sda_oe}, 32'd0);
    ack_win = 1'b0;
  endtask

  task automatic txn(input logic [6:0] a, input logic rw, input int nb, input logic [23:0] data);
    int h0, l0, s0;
    logic ok, ak;
    logic [7:0] d;
    h0 = hi_seen; l0 = lo_seen; s0 = stray;
    ok = (a == exp_addr(strap)) && !rw;
    m_start;
    m_byte({a, rw}, ak);
    check(ok ? "R2 header ack" : "R3 header nack", {31'd0, ak}, {31'd0, ok});
    for (int k = 0; k < nb; k++) begin
      d = data[23 - 8 * k -: 8];
      m_byte(d, ak);
      if (k == 0) check("R5 high byte ack", {31'd0, ak}, {31'd0, ok});
      else if (k == 1) check("R6 low byte ack", {31'd0, ak}, {31'd0, ok});
      else check("R7 extra byte nack", {31'd0, ak}, 32'd0);
      if (ok && k == 0) word_exp[15:8] = d;
      if (ok && k == 1) word_exp[7:0] = d;
    end
    m_stop;
    idle(2);
    check("R5 R6 word value", {16'd0, word}, {16'd0, word_exp});
    check("R5 high strobe count", hi_seen - h0, (ok && nb >= 1) ? 1 : 0);
    check("R6 low strobe count", lo_seen - l0, (ok && nb >= 2) ? 1 : 0);
    check("R7 no drive outside ack", stray - s0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic ak;
    logic [15:0] w0;
    void'($urandom(32'h1a2b3c4d));
    idle(4);
    check("R10 word in reset", {16'd0, word}, 32'd0);
    check("R10 enable in reset", {31'd0, sda_oe}, 32'd0);
    rst = 1'b0;
    idle(10);
    check("R10 word after reset", {16'd0, word}, 32'd0);
    check("R10 strobes after reset", {30'd0, hi_stb, lo_stb}, 32'd0);

    // R2: both strap settings
    txn(7'b0010111, 1'b0, 2, 24'hA55A00);
    strap = 1'b1; idle(Q);
    txn(7'b0010111, 1'b0, 2, 24'h123400);
    txn(7'b0010110, 1'b0, 2, 24'hC3E100);
    strap = 1'b0; idle(Q);
    // R3: read bit set
    txn(7'b0010111, 1'b1, 2, 24'h0F0F00);
    // R5: high byte only
    txn(7'b0010111, 1'b0, 1, 24'h7700_00);
    // R7: third byte ignored
    txn(7'b0010111, 1'b0, 3, 24'h89ABCD);

    // R1: bits without START are ignored
    w0 = word;
    scl_m = 1'b0; idle(Q);
    m_byte({exp_addr(strap), 1'b0}, ak);
    check("R1 no ack without START", {31'd0, ak}, 32'd0);
    m_byte(8'h55, ak);
    m_stop; idle(2);
    check("R1 word unchanged without START", {16'd0, word}, {16'd0, w0});

    // R9: STOP inside a data byte
    m_start;
    m_byte({exp_addr(strap), 1'b0}, ak);
    check("R9 header ack", {31'd0, ak}, 32'd1);
    for (int i = 0; i < 4; i++) m_bit(1'b1, 1'b0);
    m_stop; idle(2);
    check("R9 partial byte discarded", {16'd0, word}, {16'd0, w0});
    txn(7'b0010111, 1'b0, 2, 24'h3C9600);

    // R8: repeated START mid-word
    m_start;
    m_byte({exp_addr(strap), 1'b0}, ak);
    m_byte(8'hE7, ak);
    word_exp[15:8] = 8'hE7;
    for (int i = 0; i < 3; i++) m_bit(1'b0, 1'b0);
    m_start;
    m_byte({exp_addr(strap), 1'b0}, ak);
    check("R8 header ack after repeated START", {31'd0, ak}, 32'd1);
    m_byte(8'h18, ak);
    m_byte(8'h81, ak);
    word_exp = 16'h1881;
    m_stop; idle(2);
    check("R8 word after repeated START", {16'd0, word}, {16'd0, word_exp});

    // Random transactions
    for (int t = 0; t < 30; t++) begin
      logic [6:0] a;
      logic rw;
      strap = 1'($urandom % 2);
      idle(Q);
      a = ($urandom % 4 == 0) ? 7'($urandom) : exp_addr(strap);
      rw = ($urandom % 5 == 0);
      txn(a, rw, int'($urandom % 4), 24'($urandom));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule